// File: doc/BRIEF.md
# Strip-Mining Length Sequencer

This block takes an element count `n`, known only at run time, and breaks it into pieces that a downstream vector unit can process. No piece is longer than the maximum vector length (parameter `MVL`, default 64). A one-cycle `start_i` pulse captures `n`. The block then offers one chunk at a time on a valid/ready channel. Each chunk carries the index of its first element, its length, and a flag that marks the final chunk. After the vector unit accepts a chunk, the sequencer waits for a separate completion acknowledgement before it offers the next one.

The short piece comes first. The first chunk holds `n mod MVL` elements and every later chunk holds exactly `MVL`. When `n` is an exact multiple of `MVL`, the empty leading piece is not issued and the sequence starts with a full chunk. When `n` is zero, no chunk is issued and the done pulse follows at once. After the final chunk is acknowledged, `done_o` pulses for one cycle.

Top module: `strip_seq`

## Requirements
- R1: For a nonzero count whose remainder modulo MVL is nonzero, the first chunk's length equals `n mod MVL`, and its low index is 0.
- R2: Every chunk after the first has length MVL. Whenever a chunk is offered, its length is between 1 and MVL inclusive.
- R3: For nonzero `n`, the number of chunks offered is ceil(`n`/MVL). An empty leading chunk (remainder zero) is never offered.
- R4: Each chunk's low index equals the previous chunk's low index plus the previous chunk's length.
- R5: `chunk_last_o` is 1 on the final chunk of a sequence and 0 on all others. The lengths of a sequence sum to `n`.
- R6: A start with `n` = 0 makes `done_o` high for exactly one cycle, on the cycle after the start is sampled, and no chunk is offered.
- R7: `done_o` goes high for exactly one cycle, on the cycle after the acknowledgement of the final chunk is sampled.
- R8: While `chunk_valid_o` is high and `chunk_ready_i` is low, the valid, low index, length and last outputs hold their values.
- R9: After a chunk is accepted (valid and ready both high at a clock edge), `chunk_valid_o` is low until `chunk_ack_i` is sampled high. An acknowledgement while a chunk is being offered, or while idle, has no effect. A start while a sequence is running is ignored.
- R10: After synchronous reset, `chunk_valid_o` and `done_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse; captures `count_i` when idle |
| count_i | input | CNT_W | Total element count `n`, unsigned |
| chunk_valid_o | output | 1 | Chunk offered |
| chunk_ready_i | input | 1 | Downstream accepts the offered chunk |
| chunk_low_o | output | CNT_W | Index of the chunk's first element, counted from 0 |
| chunk_len_o | output | clog2(MVL+1) | Number of elements in the chunk |
| chunk_last_o | output | 1 | Chunk is the final one of the sequence |
| chunk_ack_i | input | 1 | Downstream has finished the accepted chunk |
| done_o | output | 1 | One-cycle pulse when the sequence ends |

## Verification
The hardest situation to reach from the ports is the gap between acceptance and acknowledgement. In that window the block must stay silent even though stray starts and acknowledgements arrive. The bench holds `chunk_ready_i` low for several cycles while it raises an early acknowledgement. It then accepts the chunk, sends a start with a different count, and only after that sends the real acknowledgement, so any early advance or restart changes the observed chunk stream. The counts on either side of each MVL boundary (63, 64, 65, 127, 128, 129) exercise the skipped empty first chunk and the one-element first chunk.

// File: rtl/strip_pkg.sv
package strip_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_OFFER = 2'd1,
    ST_WAIT  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/strip_split.sv
// Works out the leading piece of a fresh count.
module strip_split #(
  parameter int CNT_W = 32,
  parameter int MVL   = 64,
  parameter int LEN_W = 7
) (
  input  logic [CNT_W-1:0] n_i,
  output logic [LEN_W-1:0] first_len_o,
  output logic [CNT_W-1:0] rest_o,
  output logic             zero_o
);
  localparam int LOG = $clog2(MVL);
  localparam bit POW2 = ((1 << LOG) == MVL);
  localparam logic [CNT_W-1:0] MVL_C = CNT_W'(MVL);

  logic [LEN_W-1:0] rem_part;

  generate
    if (POW2) begin : g_mask
      assign rem_part = LEN_W'(n_i[LOG-1:0]);
    end else begin : g_mod
      logic [CNT_W-1:0] full_mod;
      assign full_mod = n_i % MVL_C;
      assign rem_part = full_mod[LEN_W-1:0];
    end
  endgenerate

  always_comb begin
    zero_o      = (n_i == '0);
    first_len_o = (rem_part == '0) ? LEN_W'(MVL) : rem_part;
    rest_o      = n_i - {{(CNT_W-LEN_W){1'b0}}, first_len_o};
  end
endmodule

// File: rtl/strip_advance.sv
// Next-chunk arithmetic applied when a chunk is acknowledged.
module strip_advance #(
  parameter int CNT_W = 32,
  parameter int MVL   = 64,
  parameter int LEN_W = 7
) (
  input  logic [CNT_W-1:0] low_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [CNT_W-1:0] rem_i,
  output logic [CNT_W-1:0] low_o,
  output logic [CNT_W-1:0] rem_o,
  output logic             last_o
);
  localparam logic [CNT_W-1:0] MVL_C = CNT_W'(MVL);

  always_comb begin
    low_o  = low_i + {{(CNT_W-LEN_W){1'b0}}, len_i};
    rem_o  = rem_i - MVL_C;
    last_o = (rem_i <= MVL_C);
  end
endmodule

// File: rtl/strip_seq.sv
module strip_seq
  import strip_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int MVL   = 64
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      start_i,
  input  logic [CNT_W-1:0]          count_i,
  output logic                      chunk_valid_o,
  input  logic                      chunk_ready_i,
  output logic [CNT_W-1:0]          chunk_low_o,
  output logic [$clog2(MVL+1)-1:0]  chunk_len_o,
  output logic                      chunk_last_o,
  input  logic                      chunk_ack_i,
  output logic                      done_o
);
  localparam int LEN_W = $clog2(MVL+1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] rem_q;

  logic [LEN_W-1:0] first_len;
  logic [CNT_W-1:0] first_rest;
  logic             n_zero;
  logic [CNT_W-1:0] nxt_low;
  logic [CNT_W-1:0] nxt_rem;
  logic             nxt_last;

  strip_split #(.CNT_W(CNT_W), .MVL(MVL), .LEN_W(LEN_W)) u_split (
    .n_i         (count_i),
    .first_len_o (first_len),
    .rest_o      (first_rest),
    .zero_o      (n_zero)
  );

  strip_advance #(.CNT_W(CNT_W), .MVL(MVL), .LEN_W(LEN_W)) u_adv (
    .low_i  (chunk_low_o),
    .len_i  (chunk_len_o),
    .rem_i  (rem_q),
    .low_o  (nxt_low),
    .rem_o  (nxt_rem),
    .last_o (nxt_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_IDLE;
      rem_q         <= '0;
      chunk_valid_o <= 1'b0;
      chunk_low_o   <= '0;
      chunk_len_o   <= '0;
      chunk_last_o  <= 1'b0;
      done_o        <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            if (n_zero) begin
              done_o <= 1'b1;
            end else begin
              chunk_valid_o <= 1'b1;
              chunk_low_o   <= '0;
              chunk_len_o   <= first_len;
              chunk_last_o  <= (first_rest == '0);
              rem_q         <= first_rest;
              state_q       <= ST_OFFER;
            end
          end
        end
        ST_OFFER: begin
          if (chunk_ready_i) begin
            chunk_valid_o <= 1'b0;
            state_q       <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (chunk_ack_i) begin
            if (chunk_last_o) begin
              done_o  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              chunk_valid_o <= 1'b1;
              chunk_low_o   <= nxt_low;
              chunk_len_o   <= LEN_W'(MVL);
              chunk_last_o  <= nxt_last;
              rem_q         <= nxt_rem;
              state_q       <= ST_OFFER;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/strip_seq_chk.sv
module strip_seq_chk #(
  parameter int CNT_W = 32,
  parameter int MVL   = 64,
  parameter int LEN_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             valid,
  input logic             ready,
  input logic [CNT_W-1:0] low,
  input logic [LEN_W-1:0] len,
  input logic             last,
  input logic             done
);
  logic [CNT_W-1:0] expect_low;
  logic             mid_seq;

  always_ff @(posedge clk) begin
    if (rst) begin
      expect_low <= '0;
      mid_seq    <= 1'b0;
    end else if (valid && ready) begin
      expect_low <= low + {{(CNT_W-LEN_W){1'b0}}, len};
      mid_seq    <= !last;
    end
  end

  assert_len_bound_R2: assert property (@(posedge clk) disable iff (rst)
    valid |-> (len != '0) && (len <= LEN_W'(MVL)));

  assert_hold_stall_R8: assert property (@(posedge clk) disable iff (rst)
    (valid && !ready) |=> valid && $stable(low) && $stable(len) && $stable(last));

  assert_quiet_after_accept_R9: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> !valid);

  assert_done_single_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_no_done_while_offer_R9: assert property (@(posedge clk) disable iff (rst)
    !(valid && done));

  assert_low_contiguous_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(valid) && mid_seq) |-> (low == expect_low));
endmodule

bind strip_seq strip_seq_chk #(.CNT_W(CNT_W), .MVL(MVL), .LEN_W(LEN_W)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .valid (chunk_valid_o),
  .ready (chunk_ready_i),
  .low   (chunk_low_o),
  .len   (chunk_len_o),
  .last  (chunk_last_o),
  .done  (done_o)
);

// File: tb/tb_strip_seq.sv
module tb_strip_seq;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 32;
  localparam int MVL   = 64;
  localparam int LEN_W = $clog2(MVL+1);
  localparam int NV = 9;
  localparam logic [31:0] VEC_N[NV]     = '{32'd1, 32'd63, 32'd64, 32'd65, 32'd127,
                                            32'd128, 32'd129, 32'd300, 32'd1000};
  localparam int          VEC_CNT[NV]   = '{1, 1, 1, 2, 2, 2, 3, 5, 16};
  localparam int          VEC_FIRST[NV] = '{1, 63, 64, 1, 63, 64, 1, 44, 40};

  logic clk = 1'b0;
  logic rst, start_i, chunk_ready_i, chunk_ack_i;
  logic [CNT_W-1:0] count_i;
  logic chunk_valid_o, chunk_last_o, done_o;
  logic [CNT_W-1:0] chunk_low_o;
  logic [LEN_W-1:0] chunk_len_o;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  strip_seq #(.CNT_W(CNT_W), .MVL(MVL)) dut (
    .clk(clk), .rst(rst), .start_i(start_i), .count_i(count_i),
    .chunk_valid_o(chunk_valid_o), .chunk_ready_i(chunk_ready_i),
    .chunk_low_o(chunk_low_o), .chunk_len_o(chunk_len_o),
    .chunk_last_o(chunk_last_o), .chunk_ack_i(chunk_ack_i), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_seq(input logic [31:0] n, input int exp_cnt,
                         input int exp_first, input int stall);
    longint exp_low = 0;
    longint sum = 0;
    int chunks = 0;
    bit seen_last = 0;
    @(negedge clk); start_i = 1'b1; count_i = n;
    @(negedge clk); start_i = 1'b0;
    while (!seen_last && chunks < 100) begin
      int w = 0;
      while (!chunk_valid_o && w < 20) begin @(negedge clk); w++; end
      chk(chunk_valid_o == 1'b1, "R3", "chunk offered", chunk_valid_o, 1);
      if (!chunk_valid_o) break;
      if (chunks == 0) begin
        chk(chunk_len_o == exp_first, "R1", "first length", chunk_len_o, exp_first);
      end else begin
        chk(chunk_len_o == MVL, "R2", "later length", chunk_len_o, MVL);
      end
      chk(chunk_low_o == exp_low, "R4", "low index", chunk_low_o, exp_low);
      chk(chunk_last_o == (chunks == exp_cnt-1), "R5", "last flag",
          chunk_last_o, (chunks == exp_cnt-1));
      begin
        longint l0 = chunk_low_o;
        longint n0 = chunk_len_o;
        bit f0 = chunk_last_o;
        chunk_ack_i = (stall > 0);
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(chunk_valid_o && chunk_low_o == l0 && chunk_len_o == n0 &&
              chunk_last_o == f0, "R8", "stall hold low", chunk_low_o, l0);
        end
        chunk_ack_i = 1'b0;
      end
      seen_last = chunk_last_o;
      sum += chunk_len_o;
      exp_low += chunk_len_o;
      chunks++;
      chunk_ready_i = 1'b1;
      @(negedge clk); chunk_ready_i = 1'b0;
      chk(chunk_valid_o == 1'b0, "R9", "valid drops after accept", chunk_valid_o, 0);
      start_i = 1'b1; count_i = 32'd5;
      @(negedge clk); start_i = 1'b0;
      @(negedge clk);
      chk(!chunk_valid_o && !done_o, "R9", "silent before ack",
          chunk_valid_o | done_o, 0);
      chunk_ack_i = 1'b1;
      @(negedge clk); chunk_ack_i = 1'b0;
      if (seen_last) begin
        chk(done_o == 1'b1, "R7", "done after final ack", done_o, 1);
        chk(chunk_valid_o == 1'b0, "R7", "no chunk with done", chunk_valid_o, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R7", "done one cycle", done_o, 0);
      end else begin
        chk(chunk_valid_o == 1'b1, "R9", "next chunk after ack", chunk_valid_o, 1);
      end
    end
    chk(chunks == exp_cnt, "R3", "chunk count", chunks, exp_cnt);
    chk(sum == n, "R5", "length sum", sum, n);
  endtask

  initial begin
    #(CLK_PERIOD*150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; chunk_ready_i = 1'b0; chunk_ack_i = 1'b0;
    count_i = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(chunk_valid_o == 1'b0, "R10", "valid after reset", chunk_valid_o, 0);
    chk(done_o == 1'b0, "R10", "done after reset", done_o, 0);

    for (int i = 0; i < NV; i++) begin
      run_seq(VEC_N[i], VEC_CNT[i], VEC_FIRST[i], i % 3);
      repeat (2) @(negedge clk);
    end

    // R6: zero count
    start_i = 1'b1; count_i = '0;
    @(negedge clk); start_i = 1'b0;
    chk(done_o == 1'b1, "R6", "done for zero count", done_o, 1);
    chk(chunk_valid_o == 1'b0, "R6", "no chunk for zero count", chunk_valid_o, 0);
    @(negedge clk);
    chk(done_o == 1'b0, "R6", "zero-count done one cycle", done_o, 0);
    repeat (3) begin
      @(negedge clk);
      chk(chunk_valid_o == 1'b0, "R6", "still no chunk", chunk_valid_o, 0);
    end

    // R9: ack while idle has no effect
    chunk_ack_i = 1'b1;
    @(negedge clk); chunk_ack_i = 1'b0;
    @(negedge clk);
    chk(!chunk_valid_o && !done_o, "R9", "idle ack ignored",
        chunk_valid_o | done_o, 0);

    // Large count with a one-element first chunk, mid-sequence reset (R10)
    run_seq(32'd193, 4, 1, 0);
    @(negedge clk); start_i = 1'b1; count_i = 32'd500;
    @(negedge clk); start_i = 1'b0;
    chk(chunk_valid_o == 1'b1, "R1", "offer before reset", chunk_valid_o, 1);
    chk(chunk_len_o == 52, "R1", "500 mod 64", chunk_len_o, 52);
    rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(chunk_valid_o == 1'b0 && done_o == 1'b0, "R10", "reset mid sequence",
        chunk_valid_o | done_o, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule